// File: doc/BRIEF.md
# Configurable Serial Sample Framer

The framer takes one parallel sample per word period and sends it out as a single serial bit stream. Alongside the stream it produces a frame clock that marks word boundaries and a data clock whose phase against the data edges can be set. Everything runs from one fast single-data-rate clock. Each serial bit lasts three fast-clock ticks, so one data-clock period (two bits) spans six ticks, and one tick is a 60° phase step.

A small register-style port sets four things: the serial word length (shortened, native or zero-padded), the bit order, the output polarity and the data-clock phase. Writes go to a pending copy. The pending copy becomes active only at a word boundary, so a word is never cut short or mixed between two settings. The upstream source watches `take_o`: the sample present on `sample_i` at the clock edge that ends a pulse of `take_o` is the one that goes out in the next word.

Top module: `sfr_framer`

## Requirements
- R1: While `rst_n` is low, `ser_o`, `fclk_o` and `dclk_o` are 0 and `take_o` is 1. At the first clock edge after release, a word starts with the reset settings.
- R2: With reset settings, the serial word is 12 bits, most significant bit first, and each bit is held for exactly 3 clock ticks.
- R3: Config address 0 takes a length code in `cfg_data_i[1:0]`: 0 gives 8 bits, 1 gives 10, 2 gives 12 and 3 gives 14. The word period is 3 ticks times the word length.
- R4: Config address 1, bit 0 set to 1 sends the word least significant bit first, which is the exact reverse of the most-significant-first order for the same length.
- R5: Config address 2, bit 0 set to 1 complements every serial bit, padding included.
- R6: In the 8-bit and 10-bit modes the word carries only the top 8 or 10 sample bits. The low bits are dropped.
- R7: In the 14-bit mode, the most-significant-first word is the 12 sample bits followed by two 0 bits.
- R8: `fclk_o` is 1 for the first half of the bits of each word and 0 for the second half, so it rises only at a word start.
- R9: `dclk_o` has a period of 6 ticks and is high for 3 of them. Phase code p (address 3, values 0 to 5) delays it by p ticks (p × 60°) from the position where it rises with the first bit of a word.
- R10: The reset phase code is 2, the tick nearest to 90°. After reset the first rise of `dclk_o` comes 2 ticks into the first word.
- R11: `take_o` is a one-tick pulse in the last tick of each word. The sample is captured at the edge that ends it.
- R12: A configuration write takes effect only from the next word start. A write at the boundary edge itself first applies one word later.
- R13: A phase write with a value of 6 or more is ignored, and the previous phase is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, three ticks per serial bit |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_i | input | 12 | Parallel sample, captured when a word starts |
| take_o | output | 1 | Sample is captured at the next edge |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration field select (0 length, 1 order, 2 invert, 3 phase) |
| cfg_data_i | input | 3 | Configuration write value |
| ser_o | output | 1 | Serial data stream |
| fclk_o | output | 1 | Frame clock |
| dclk_o | output | 1 | Phase-adjustable data clock |

## Verification
The checker watches four things on every cycle. Serial data holds steady within a bit. The capture pulse lasts exactly one tick. The frame clock rises only just after a capture. The active settings and phase never change except at a boundary, and the active phase stays in range. The bench alone can show that each bit position carries the right sample bit under every combination of length, order and polarity, that padding and truncation are correct, and where the data-clock edges sit for each phase code. It can also show that a write made at the boundary edge is deferred by one whole word and that an out-of-range phase value is dropped.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

   typedef enum logic [1:0] {
      LEN_CUT4  = 2'd0,
      LEN_CUT2  = 2'd1,
      LEN_FULL  = 2'd2,
      LEN_PAD   = 2'd3
   } len_e;

   typedef struct packed {
      len_e len;
      logic lsb_first;
      logic invert;
   } sfr_cfg_t;

   localparam logic [1:0] ADDR_LEN   = 2'd0;
   localparam logic [1:0] ADDR_ORDER = 2'd1;
   localparam logic [1:0] ADDR_INV   = 2'd2;
   localparam logic [1:0] ADDR_PHASE = 2'd3;

   function automatic int unsigned word_bits(len_e l, int unsigned smp_w, int unsigned pad_w);
      case (l)
         LEN_CUT4: return smp_w - 4;
         LEN_CUT2: return smp_w - 2;
         LEN_FULL: return smp_w;
         default:  return smp_w + pad_w;
      endcase
   endfunction

endpackage

// File: rtl/sfr_cfg.sv
module sfr_cfg #(
   parameter int unsigned PH_W     = 3,
   parameter int unsigned PH_STEPS = 6,
   parameter int unsigned PH_RST   = 2,
   parameter int unsigned DW       = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr,
   input  logic [1:0]            addr,
   input  logic [DW-1:0]         wdata,
   input  logic                  load,
   output sfr_pkg::sfr_cfg_t     cfg_o,
   output logic [PH_W-1:0]       phase_o
);
   import sfr_pkg::*;

   localparam sfr_cfg_t CFG_RST = '{len: LEN_FULL, lsb_first: 1'b0, invert: 1'b0};

   sfr_cfg_t        pend_q;
   logic [PH_W-1:0] pend_ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= CFG_RST;
         pend_ph_q <= PH_W'(PH_RST);
         cfg_o     <= CFG_RST;
         phase_o   <= PH_W'(PH_RST);
      end else begin
         if (load) begin
            cfg_o   <= pend_q;
            phase_o <= pend_ph_q;
         end
         if (wr) begin
            case (addr)
               ADDR_LEN:   pend_q.len       <= len_e'(wdata[1:0]);
               ADDR_ORDER: pend_q.lsb_first <= wdata[0];
               ADDR_INV:   pend_q.invert    <= wdata[0];
               default: begin
                  if (wdata < DW'(PH_STEPS))
                     pend_ph_q <= wdata[PH_W-1:0];
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/sfr_timing.sv
module sfr_timing #(
   parameter int unsigned TPB   = 3,
   parameter int unsigned LEN_W = 4,
   parameter int unsigned PH_W  = 3,
   localparam int unsigned TK_W = (TPB > 1) ? $clog2(TPB) : 1,
   localparam int unsigned DCP  = 2 * TPB
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] word_len,
   input  logic [PH_W-1:0]  phase,
   output logic             load_o,
   output logic             act_o,
   output logic [LEN_W-1:0] bit_o,
   output logic [TK_W-1:0]  tick_o,
   output logic             fclk_o,
   output logic             dclk_o
);
   logic             act_q;
   logic [LEN_W-1:0] bit_q;
   logic [TK_W-1:0]  tick_q;
   logic [PH_W-1:0]  cyc_q;
   logic             last_tick, last_bit;
   logic [PH_W:0]    rot;

   assign last_tick = (tick_q == TK_W'(TPB - 1));
   assign last_bit  = (bit_q == word_len - LEN_W'(1));
   assign load_o    = !act_q || (last_tick && last_bit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         bit_q  <= '0;
         tick_q <= '0;
         cyc_q  <= '0;
      end else if (load_o) begin
         act_q  <= 1'b1;
         bit_q  <= '0;
         tick_q <= '0;
         cyc_q  <= '0;
      end else begin
         if (last_tick) begin
            tick_q <= '0;
            bit_q  <= bit_q + LEN_W'(1);
         end else begin
            tick_q <= tick_q + TK_W'(1);
         end
         cyc_q <= (cyc_q == PH_W'(DCP - 1)) ? '0 : cyc_q + PH_W'(1);
      end
   end

   always_comb begin
      rot = {1'b0, cyc_q} + (PH_W+1)'(DCP) - {1'b0, phase};
      if (rot >= (PH_W+1)'(DCP))
         rot = rot - (PH_W+1)'(DCP);
   end

   assign act_o  = act_q;
   assign bit_o  = bit_q;
   assign tick_o = tick_q;
   assign fclk_o = act_q && (bit_q < (word_len >> 1));
   assign dclk_o = act_q && (rot < (PH_W+1)'(TPB));

endmodule

// File: rtl/sfr_bitsel.sv
module sfr_bitsel #(
   parameter int unsigned SMP_W = 12,
   parameter int unsigned PAD_W = 2,
   parameter int unsigned LEN_W = 4,
   localparam int unsigned MAXW = SMP_W + PAD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             act,
   input  logic [SMP_W-1:0] sample,
   input  logic [LEN_W-1:0] word_len,
   input  logic [LEN_W-1:0] bit_idx,
   input  logic             lsb_first,
   input  logic             invert,
   output logic             ser_o
);
   logic [MAXW-1:0] word_q;
   logic [MAXW-1:0] word_d;
   logic [MAXW-1:0] msb_seq;
   logic [LEN_W-1:0] rev_idx, sel_idx;

   if (PAD_W > 0) begin : g_pad
      assign word_d = {sample, {PAD_W{1'b0}}};
   end else begin : g_nopad
      assign word_d = sample;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         word_q <= '0;
      else if (load)
         word_q <= word_d;
   end

   for (genvar k = 0; k < MAXW; k++) begin : g_seq
      assign msb_seq[k] = word_q[MAXW-1-k];
   end

   assign rev_idx = word_len - LEN_W'(1) - bit_idx;
   assign sel_idx = lsb_first ? rev_idx : bit_idx;
   assign ser_o   = act && (msb_seq[sel_idx] ^ invert);

endmodule

// File: rtl/sfr_framer.sv
module sfr_framer #(
   parameter int unsigned SMP_W   = 12,
   parameter int unsigned PAD_W   = 2,
   parameter int unsigned TPB     = 3,
   parameter int unsigned DEF_DEG = 90,
   localparam int unsigned MAXW   = SMP_W + PAD_W,
   localparam int unsigned LEN_W  = $clog2(MAXW + 1),
   localparam int unsigned DCP    = 2 * TPB,
   localparam int unsigned PH_W   = (DCP > 2) ? $clog2(DCP) : 1,
   localparam int unsigned PH_RST = (DEF_DEG * DCP + 180) / 360,
   localparam int unsigned CFG_DW = (PH_W > 2) ? PH_W : 2,
   localparam int unsigned TK_W   = (TPB > 1) ? $clog2(TPB) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SMP_W-1:0]  sample_i,
   output logic              take_o,
   input  logic              cfg_wr_i,
   input  logic [1:0]        cfg_addr_i,
   input  logic [CFG_DW-1:0] cfg_data_i,
   output logic              ser_o,
   output logic              fclk_o,
   output logic              dclk_o
);
   if (SMP_W < 6 || (SMP_W % 2) != 0) begin : g_bad_smp
      $error("sfr_framer: SMP_W must be even and at least 6");
   end
   if ((PAD_W % 2) != 0) begin : g_bad_pad
      $error("sfr_framer: PAD_W must be even");
   end
   if (TPB < 1) begin : g_bad_tpb
      $error("sfr_framer: TPB must be at least 1");
   end
   if (PH_RST >= DCP) begin : g_bad_ph
      $error("sfr_framer: DEF_DEG rounds outside the phase range");
   end

   sfr_pkg::sfr_cfg_t act_cfg;
   logic [PH_W-1:0]   act_ph;
   logic [LEN_W-1:0]  word_len, bit_idx;
   logic [TK_W-1:0]   tick;
   logic              load, act;

   assign word_len = LEN_W'(sfr_pkg::word_bits(act_cfg.len, SMP_W, PAD_W));
   assign take_o   = load;

   sfr_cfg #(.PH_W(PH_W), .PH_STEPS(DCP), .PH_RST(PH_RST), .DW(CFG_DW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr_i), .addr(cfg_addr_i), .wdata(cfg_data_i),
      .load(load), .cfg_o(act_cfg), .phase_o(act_ph)
   );

   sfr_timing #(.TPB(TPB), .LEN_W(LEN_W), .PH_W(PH_W)) u_tim (
      .clk(clk), .rst_n(rst_n), .word_len(word_len), .phase(act_ph),
      .load_o(load), .act_o(act), .bit_o(bit_idx), .tick_o(tick),
      .fclk_o(fclk_o), .dclk_o(dclk_o)
   );

   sfr_bitsel #(.SMP_W(SMP_W), .PAD_W(PAD_W), .LEN_W(LEN_W)) u_bits (
      .clk(clk), .rst_n(rst_n), .load(load), .act(act), .sample(sample_i),
      .word_len(word_len), .bit_idx(bit_idx), .lsb_first(act_cfg.lsb_first),
      .invert(act_cfg.invert), .ser_o(ser_o)
   );

endmodule

// File: rtl/sfr_framer_chk.sv
module sfr_framer_chk #(
   parameter int unsigned TK_W     = 2,
   parameter int unsigned PH_W     = 3,
   parameter int unsigned PH_STEPS = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            take,
   input logic            ser,
   input logic            fclk,
   input logic [TK_W-1:0] tick,
   input logic [1:0]      act_len,
   input logic [PH_W-1:0] act_ph
);
   // R2: a serial bit is held for all ticks of its bit period
   assert_bit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick != '0) |-> $stable(ser));

   // R11: the capture pulse lasts one tick
   assert_take_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !take);

   // R8: the frame clock rises only right after a capture
   assert_frame_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fclk) |-> $past(take));

   // R12: active settings move only at a word boundary
   assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> ($stable(act_len) && $stable(act_ph)));

   // R13: the active phase never leaves the legal range
   assert_phase_range_R13: assert property (@(posedge clk) disable iff (!rst_n)
      act_ph < PH_W'(PH_STEPS));

endmodule

bind sfr_framer sfr_framer_chk #(.TK_W(TK_W), .PH_W(PH_W), .PH_STEPS(DCP)) u_chk (
   .clk(clk), .rst_n(rst_n), .take(take_o), .ser(ser_o), .fclk(fclk_o),
   .tick(tick), .act_len(act_cfg.len), .act_ph(act_ph)
);

// File: tb/sim_sfr_framer.sv
module sim_sfr_framer;
   localparam int TPB = 3;
   localparam int DCP = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] sample = '0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [2:0]  cfg_data = '0;
   logic        take, ser, fclk, dclk;

   int n_cmp = 0, n_bad = 0;
   bit started = 0, done = 0;

   // reference model state
   int m_act = 0, m_bi = 0, m_tk = 0, m_c = 0, m_w = 12, m_ord = 0, m_inv = 0, m_ph = 2;
   int p_len = 2, p_ord = 0, p_inv = 0, p_ph = 2;
   int m_bits[14];

   sfr_framer u0 (
      .clk(clk), .rst_n(rst_n), .sample_i(sample), .take_o(take),
      .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
      .ser_o(ser), .fclk_o(fclk), .dclk_o(dclk)
   );

   always #4 clk = ~clk;

   task automatic chk(string tag, logic got, logic exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: got %0b expected %0b", tag, $time, got, exp);
      end
   endtask

   task automatic chk_int(string tag, int got, int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s at %0t: got %0d expected %0d", tag, $time, got, exp);
      end
   endtask

   task automatic finish_run();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   function automatic int msb_bit(logic [11:0] s, int j);
      return (j < 12) ? int'(s[11-j]) : 0;
   endfunction

   // behavioural model, advanced on every rising edge
   always @(posedge clk) begin
      started = 1;
      if (!rst_n) begin
         m_act = 0; m_bi = 0; m_tk = 0; m_c = 0;
         m_w = 12; m_ord = 0; m_inv = 0; m_ph = 2;
         p_len = 2; p_ord = 0; p_inv = 0; p_ph = 2;
      end else begin
         if (m_act == 0 || (m_bi == m_w - 1 && m_tk == TPB - 1)) begin
            m_act = 1;
            m_w = 8 + 2 * p_len; m_ord = p_ord; m_inv = p_inv; m_ph = p_ph;
            for (int k = 0; k < 14; k++)
               m_bits[k] = (k >= m_w) ? 0 : (m_ord != 0) ? msb_bit(sample, m_w - 1 - k) : msb_bit(sample, k);
            m_bi = 0; m_tk = 0; m_c = 0;
         end else begin
            if (m_tk == TPB - 1) begin m_tk = 0; m_bi++; end
            else m_tk++;
            m_c = (m_c + 1) % DCP;
         end
         if (cfg_wr) begin
            case (cfg_addr)
               2'd0: p_len = int'(cfg_data[1:0]);
               2'd1: p_ord = int'(cfg_data[0]);
               2'd2: p_inv = int'(cfg_data[0]);
               default: if (cfg_data < 3'd6) p_ph = int'(cfg_data);
            endcase
         end
      end
   end

   // compare outputs against the model away from the clock edge
   always @(negedge clk) begin
      if (started && !done) begin
         logic e_ser, e_f, e_d, e_t;
         string ts;
         e_ser = (m_act != 0) && ((m_bits[m_bi] ^ m_inv) != 0);
         e_f   = (m_act != 0) && (m_bi < m_w / 2);
         e_d   = (m_act != 0) && (((m_c - m_ph + DCP) % DCP) < TPB);
         e_t   = (m_act == 0) || (m_bi == m_w - 1 && m_tk == TPB - 1);
         if (!rst_n) begin
            chk("R1 ser", ser, 1'b0); chk("R1 fclk", fclk, 1'b0);
            chk("R1 dclk", dclk, 1'b0); chk("R1 take", take, 1'b1);
         end else begin
            ts = (m_inv != 0) ? "R5 ser" : (m_ord != 0) ? "R4 ser" :
                 (m_w == 14) ? "R7 ser" : (m_w < 12) ? "R6 ser" : "R2 ser";
            chk(ts, ser, e_ser);
            chk("R8 fclk", fclk, e_f);
            chk("R9 dclk", dclk, e_d);
            chk((m_w != 12) ? "R3 take" : "R11 take", take, e_t);
         end
      end
   end

   always @(negedge clk) if (rst_n) sample = 12'($urandom);

   task automatic wr(logic [1:0] a, logic [2:0] d);
      cfg_wr = 1'b1; cfg_addr = a; cfg_data = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic wait_take();
      while (!take) @(negedge clk);
   endtask

   task automatic measure_phase(string tag, int exp);
      int n = 0;
      @(negedge clk);
      while (!dclk && n < 20) begin n++; @(negedge clk); end
      chk_int(tag, n, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10: reset phase puts the first dclk rise two ticks into the word
      measure_phase("R10 first dclk rise offset", 2);

      // R12: write issued at the boundary edge applies one word later
      wait_take();
      cfg_wr = 1'b1; cfg_addr = 2'd0; cfg_data = 3'd3;
      @(negedge clk);
      cfg_wr = 1'b0;
      begin
         int n = 1;
         while (!take && n < 100) begin @(negedge clk); n++; end
         chk_int("R12 deferred word period", n, 36);
         n = 0;
         do begin @(negedge clk); n++; end while (!take && n < 100);
         chk_int("R3 padded word period", n, 42);
      end
      wr(2'd0, 3'd2);

      // sweep length, order, polarity and phase (R3..R7, R9)
      for (int i = 0; i < 16; i++) begin
         wr(2'd0, 3'(i % 4));
         repeat (i % 5) @(negedge clk);
         wr(2'd1, 3'((i / 4) % 2));
         wr(2'd2, 3'(i / 8));
         wr(2'd3, 3'(i % 6));
         repeat (90 + (i * 7) % 40) @(negedge clk);
      end

      // R13: out-of-range phase value leaves phase 1 in force
      wr(2'd0, 3'd2);
      wr(2'd3, 3'd1);
      wait_take(); @(negedge clk);
      wait_take(); @(negedge clk);
      wr(2'd3, 3'd7);
      wr(2'd3, 3'd6);
      wait_take(); @(negedge clk);
      wait_take();
      measure_phase("R13 phase after ignored writes", 1);

      repeat (20) @(negedge clk);
      finish_run();
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_bad++;
         $display("FAIL R11 watchdog: got timeout expected completion");
         finish_run();
      end
   end

endmodule